// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block runs one asynchronous external memory access at a time and places every control edge at a programmed tick count. A small register-style write port loads the timing: assert times for chip select, address valid, output enable and write enable; separate deassert times for reads and writes where the strobe needs them; a total length for each kind of cycle; a read sampling time; and a clock divider. Values that do not fit their field are refused and the stored field keeps its old value.

A request that arrives while the block is idle starts a cycle. A tick counter starts at zero and advances once every divider period of the system clock. Each active-low strobe is low while the tick count lies in its window. On a read, the data bus is captured at the end of the sampling tick. When the final tick of the programmed length ends, the block pulses done and returns to idle. The timing that governs a cycle is copied when the request is accepted.

Top module: `xmt_engine`

## Requirements
- R1: After reset all four strobes are high, ready is high, done, tick and the configuration error flag are low, and the read data register holds zero.
- R2: A request is accepted only while ready is high; ready is low for the rest of the cycle, and request inputs presented while busy start nothing.
- R3: With divider D and cycle index c counted from the first clock after acceptance, a strobe is low exactly when its on time <= c/D (integer division) < min(off time, cycle length). Chip select and address valid use their read deassert time on reads and their write deassert time on writes.
- R4: Output enable never goes low during a write and write enable never goes low during a read. During a write mem_doe_o is high and mem_dout_o holds the data given with the request.
- R5: A strobe whose deassert time is less than or equal to its assert time stays high for the whole cycle.
- R6: done_o is high for exactly one clock, at cycle index length*D. The block is idle in that clock with all strobes high.
- R7: On a read, rdata_o takes the value that mem_din_i had in the last system clock of the tick equal to the access time. A write, or an access time not below the cycle length, leaves rdata_o unchanged.
- R8: The divider is 1 to 4. tick_o is high in the last system clock of each tick, so it pulses exactly length times per cycle and never while idle.
- R9: Configuration field selects are: 0 cs on, 1 cs read off, 2 cs write off, 3 adv on, 4 adv read off, 5 adv write off, 6 oe on, 7 oe off, 8 we on, 9 we off, 10 read length, 11 write length, 12 access time, 13 divider. Assert times must be below 16. Deassert, length and access values must be below 32, and a length must not be zero. The divider must be 1 to 4. Select values 14 and 15 are invalid. A refused write pulses cfg_err_o for one clock and leaves the field unchanged.
- R10: An assert time of zero drives the strobe low in the very first clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 4 | Field select |
| cfg_val_i | input | 8 | Raw value for the selected field |
| cfg_err_o | output | 1 | One-clock pulse for a refused write |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Idle, request can be accepted |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| tick_o | output | 1 | Divided interface clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| adv_n_o | output | 1 | Address valid, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| mem_din_i | input | DATA_W | Data bus from memory |
| mem_dout_o | output | DATA_W | Data bus to memory |
| mem_doe_o | output | 1 | Data bus drive enable |
| rdata_o | output | DATA_W | Captured read data |

## Verification
The assertions check on every clock the properties that hold whatever the timing: strobes are high when idle, output enable and write enable keep to their direction, done is a lone pulse in an idle clock, ticks occur only while busy, read data is stable outside reads, and an error pulse follows a configuration write. Only the bench scenarios can show the numbers themselves. These are the first low clock and the low duration of each strobe under each divider, the choice between read and write deassert sets, the done latency, and which data word is sampled. They also cover the refusal of each kind of bad value, with a later cycle timed exactly as before the refused writes.

// File: rtl/xmt_pkg.sv
package xmt_pkg;
    localparam int ON_W  = 4;
    localparam int OFF_W = 5;
    localparam int CNT_W = OFF_W;
    localparam int DIV_W = 2;
    localparam int SEL_W = 4;
    localparam int VAL_W = 8;
    localparam int NSTB  = 4;

    localparam int STB_CS  = 0;
    localparam int STB_ADV = 1;
    localparam int STB_OE  = 2;
    localparam int STB_WE  = 3;

    typedef enum logic [SEL_W-1:0] {
        F_CS_ON   = 4'd0,
        F_CS_RDX  = 4'd1,
        F_CS_WRX  = 4'd2,
        F_ADV_ON  = 4'd3,
        F_ADV_RDX = 4'd4,
        F_ADV_WRX = 4'd5,
        F_OE_ON   = 4'd6,
        F_OE_X    = 4'd7,
        F_WE_ON   = 4'd8,
        F_WE_X    = 4'd9,
        F_RD_LEN  = 4'd10,
        F_WR_LEN  = 4'd11,
        F_ACCESS  = 4'd12,
        F_DIV     = 4'd13
    } field_e;

    typedef struct packed {
        logic [ON_W-1:0]  cs_on;
        logic [OFF_W-1:0] cs_rdx;
        logic [OFF_W-1:0] cs_wrx;
        logic [ON_W-1:0]  adv_on;
        logic [OFF_W-1:0] adv_rdx;
        logic [OFF_W-1:0] adv_wrx;
        logic [ON_W-1:0]  oe_on;
        logic [OFF_W-1:0] oe_x;
        logic [ON_W-1:0]  we_on;
        logic [OFF_W-1:0] we_x;
        logic [OFF_W-1:0] rd_len;
        logic [OFF_W-1:0] wr_len;
        logic [OFF_W-1:0] access;
        logic [DIV_W-1:0] div_m1;
    } cfg_t;
endpackage

// File: rtl/xmt_cfg_regs.sv
module xmt_cfg_regs
    import xmt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [VAL_W-1:0] val_i,
    output cfg_t             cfg_o,
    output logic             err_o
);
    localparam logic [VAL_W-1:0] ON_LIM  = VAL_W'(1 << ON_W);
    localparam logic [VAL_W-1:0] OFF_LIM = VAL_W'(1 << OFF_W);
    localparam logic [VAL_W-1:0] DIV_MAX = VAL_W'(1 << DIV_W);

    typedef struct packed {
        cfg_t cfg;
        logic err;
    } cst_t;

    cst_t q, d;
    logic fits_on, fits_off, nonzero, div_ok;

    always_comb begin
        fits_on  = val_i < ON_LIM;
        fits_off = val_i < OFF_LIM;
        nonzero  = val_i != '0;
        div_ok   = nonzero && (val_i <= DIV_MAX);
        d        = q;
        d.err    = 1'b0;
        if (wr_i) begin
            case (field_e'(sel_i))
                F_CS_ON:   if (fits_on)  d.cfg.cs_on   = val_i[ON_W-1:0];  else d.err = 1'b1;
                F_ADV_ON:  if (fits_on)  d.cfg.adv_on  = val_i[ON_W-1:0];  else d.err = 1'b1;
                F_OE_ON:   if (fits_on)  d.cfg.oe_on   = val_i[ON_W-1:0];  else d.err = 1'b1;
                F_WE_ON:   if (fits_on)  d.cfg.we_on   = val_i[ON_W-1:0];  else d.err = 1'b1;
                F_CS_RDX:  if (fits_off) d.cfg.cs_rdx  = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_CS_WRX:  if (fits_off) d.cfg.cs_wrx  = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_ADV_RDX: if (fits_off) d.cfg.adv_rdx = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_ADV_WRX: if (fits_off) d.cfg.adv_wrx = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_OE_X:    if (fits_off) d.cfg.oe_x    = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_WE_X:    if (fits_off) d.cfg.we_x    = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_ACCESS:  if (fits_off) d.cfg.access  = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_RD_LEN:  if (fits_off && nonzero) d.cfg.rd_len = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_WR_LEN:  if (fits_off && nonzero) d.cfg.wr_len = val_i[OFF_W-1:0]; else d.err = 1'b1;
                F_DIV:     if (div_ok) d.cfg.div_m1 = DIV_W'(val_i - VAL_W'(1)); else d.err = 1'b1;
                default:   d.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q            <= '0;
            q.cfg.rd_len <= OFF_W'(1);
            q.cfg.wr_len <= OFF_W'(1);
        end else begin
            q <= d;
        end
    end

    assign cfg_o = q.cfg;
    assign err_o = q.err;
endmodule

// File: rtl/xmt_tick_div.sv
module xmt_tick_div
    import xmt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_m1_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] pre_q, pre_d;
    logic             wrap;

    always_comb begin
        wrap   = pre_q == div_m1_i;
        tick_o = run_i && wrap;
        pre_d  = (run_i && !wrap) ? pre_q + DIV_W'(1) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end
endmodule

// File: rtl/xmt_strobe.sv
module xmt_strobe #(
    parameter int ON_W  = 4,
    parameter int OFF_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [ON_W-1:0]  on_i,
    input  logic [OFF_W-1:0] off_i,
    output logic             stb_n_o
);
    logic after_on, before_off;

    always_comb begin
        after_on   = cnt_i >= CNT_W'(on_i);
        before_off = cnt_i <  CNT_W'(off_i);
        stb_n_o    = !(active_i && after_on && before_off);
    end
endmodule

// File: rtl/xmt_engine.sv
module xmt_engine
    import xmt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [VAL_W-1:0]  cfg_val_i,
    output logic              cfg_err_o,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              ready_o,
    output logic              done_o,
    output logic              tick_o,
    output logic              cs_n_o,
    output logic              adv_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    input  logic [DATA_W-1:0] mem_din_i,
    output logic [DATA_W-1:0] mem_dout_o,
    output logic              mem_doe_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic                       busy;
        logic                       wr;
        logic [CNT_W-1:0]           cnt;
        logic                       done;
        logic [DATA_W-1:0]          rdata;
        logic [DATA_W-1:0]          wdata;
        logic [NSTB-1:0][ON_W-1:0]  on;
        logic [NSTB-1:0][OFF_W-1:0] off;
        logic [OFF_W-1:0]           len;
        logic [OFF_W-1:0]           acc;
        logic [DIV_W-1:0]           div_m1;
    } st_t;

    st_t             q, d;
    cfg_t            cfg;
    logic            tick;
    logic [NSTB-1:0] stb_n_d, stb_n_q;

    xmt_cfg_regs u_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (cfg_wr_i),
        .sel_i  (cfg_sel_i),
        .val_i  (cfg_val_i),
        .cfg_o  (cfg),
        .err_o  (cfg_err_o)
    );

    xmt_tick_div u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (q.busy),
        .div_m1_i (q.div_m1),
        .tick_o   (tick)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (req_valid_i) begin
                d.busy         = 1'b1;
                d.wr           = req_write_i;
                d.cnt          = '0;
                d.wdata        = req_wdata_i;
                d.on[STB_CS]   = cfg.cs_on;
                d.on[STB_ADV]  = cfg.adv_on;
                d.on[STB_OE]   = cfg.oe_on;
                d.on[STB_WE]   = cfg.we_on;
                d.off[STB_CS]  = req_write_i ? cfg.cs_wrx  : cfg.cs_rdx;
                d.off[STB_ADV] = req_write_i ? cfg.adv_wrx : cfg.adv_rdx;
                d.off[STB_OE]  = req_write_i ? '0 : cfg.oe_x;
                d.off[STB_WE]  = req_write_i ? cfg.we_x : '0;
                d.len          = req_write_i ? cfg.wr_len : cfg.rd_len;
                d.acc          = cfg.access;
                d.div_m1       = cfg.div_m1;
            end
        end else if (tick) begin
            if (!q.wr && (q.cnt == q.acc)) begin
                d.rdata = mem_din_i;
            end
            if (q.cnt == (q.len - OFF_W'(1))) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    for (genvar i = 0; i < NSTB; i++) begin : g_stb
        xmt_strobe #(
            .ON_W  (ON_W),
            .OFF_W (OFF_W),
            .CNT_W (CNT_W)
        ) u_stb (
            .active_i (d.busy),
            .cnt_i    (d.cnt),
            .on_i     (d.on[i]),
            .off_i    (d.off[i]),
            .stb_n_o  (stb_n_d[i])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.len   <= OFF_W'(1);
            stb_n_q <= '1;
        end else begin
            q       <= d;
            stb_n_q <= stb_n_d;
        end
    end

    assign ready_o    = !q.busy;
    assign done_o     = q.done;
    assign tick_o     = tick;
    assign cs_n_o     = stb_n_q[STB_CS];
    assign adv_n_o    = stb_n_q[STB_ADV];
    assign oe_n_o     = stb_n_q[STB_OE];
    assign we_n_o     = stb_n_q[STB_WE];
    assign mem_dout_o = q.wdata;
    assign mem_doe_o  = q.busy && q.wr;
    assign rdata_o    = q.rdata;
endmodule

// File: rtl/xmt_engine_chk.sv
module xmt_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cfg_wr_i,
    input logic              cfg_err_o,
    input logic              req_valid_i,
    input logic              ready_o,
    input logic              done_o,
    input logic              tick_o,
    input logic              cs_n_o,
    input logic              adv_n_o,
    input logic              oe_n_o,
    input logic              we_n_o,
    input logic              mem_doe_o,
    input logic [DATA_W-1:0] rdata_o
);
    p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (cs_n_o && adv_n_o && oe_n_o && we_n_o));

    p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && ready_o) |=> !ready_o);

    p_oe_read_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_doe_o |-> oe_n_o);

    p_we_write_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_doe_o |-> we_n_o);

    p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ready_o);

    p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o || mem_doe_o) |=> $stable(rdata_o));

    p_tick_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> !ready_o);

    p_err_after_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> $past(cfg_wr_i));
endmodule

bind xmt_engine xmt_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_err_o   (cfg_err_o),
    .req_valid_i (req_valid_i),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .tick_o      (tick_o),
    .cs_n_o      (cs_n_o),
    .adv_n_o     (adv_n_o),
    .oe_n_o      (oe_n_o),
    .we_n_o      (we_n_o),
    .mem_doe_o   (mem_doe_o),
    .rdata_o     (rdata_o)
);

// File: tb/sim_xmt_engine.sv
module sim_xmt_engine;
    localparam int DW = 16;

    typedef struct packed {
        logic [2:0] div;
        logic [7:0] cs_on, cs_rd, cs_wr, adv_on, adv_rd, adv_wr;
        logic [7:0] oe_on, oe_off, we_on, we_off, rlen, wlen, acc;
        logic       wr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 8'd0, 8'd10, 8'd12, 8'd0,  8'd2,  8'd3,  8'd2, 8'd9,  8'd1, 8'd8,  8'd12, 8'd14, 8'd6,  1'b0},
        '{3'd1, 8'd0, 8'd10, 8'd12, 8'd0,  8'd2,  8'd3,  8'd2, 8'd9,  8'd1, 8'd8,  8'd12, 8'd14, 8'd6,  1'b1},
        '{3'd2, 8'd1, 8'd8,  8'd6,  8'd0,  8'd1,  8'd1,  8'd3, 8'd7,  8'd2, 8'd5,  8'd9,  8'd7,  8'd4,  1'b0},
        '{3'd3, 8'd1, 8'd8,  8'd6,  8'd0,  8'd1,  8'd1,  8'd3, 8'd7,  8'd2, 8'd5,  8'd9,  8'd7,  8'd4,  1'b1},
        '{3'd4, 8'd2, 8'd2,  8'd1,  8'd0,  8'd3,  8'd3,  8'd5, 8'd4,  8'd1, 8'd1,  8'd6,  8'd5,  8'd3,  1'b0},
        '{3'd1, 8'd0, 8'd31, 8'd31, 8'd15, 8'd31, 8'd31, 8'd0, 8'd31, 8'd0, 8'd31, 8'd31, 8'd31, 8'd31, 1'b0},
        '{3'd2, 8'd3, 8'd20, 8'd4,  8'd0,  8'd2,  8'd2,  8'd1, 8'd3,  8'd2, 8'd4,  8'd10, 8'd4,  8'd9,  1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [3:0]    cfg_sel = '0;
    logic [7:0]    cfg_val = '0;
    logic          cfg_err;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, done, tick;
    logic          cs_n, adv_n, oe_n, we_n;
    logic [DW-1:0] mem_din = '0;
    logic [DW-1:0] mem_dout;
    logic          mem_doe;
    logic [DW-1:0] rdata;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;
    int exp_rdata = 0;

    always #10 clk = ~clk;

    xmt_engine #(.DATA_W(DW)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_wr_i    (cfg_wr),
        .cfg_sel_i   (cfg_sel),
        .cfg_val_i   (cfg_val),
        .cfg_err_o   (cfg_err),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_wdata_i (req_wdata),
        .ready_o     (ready),
        .done_o      (done),
        .tick_o      (tick),
        .cs_n_o      (cs_n),
        .adv_n_o     (adv_n),
        .oe_n_o      (oe_n),
        .we_n_o      (we_n),
        .mem_din_i   (mem_din),
        .mem_dout_o  (mem_dout),
        .mem_doe_o   (mem_doe),
        .rdata_o     (rdata)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input int val, input bit exp_err);
        @(negedge clk);
        cfg_wr  = 1'b1;
        cfg_sel = 4'(sel);
        cfg_val = 8'(val);
        @(negedge clk);
        cfg_wr = 1'b0;
        check(cfg_err == exp_err, $sformatf("R9 cfg sel %0d val %0d err", sel, val),
              int'(cfg_err), int'(exp_err));
    endtask

    task automatic load_cfg(input vec_t v);
        cfg_write(0,  v.cs_on,  1'b0);
        cfg_write(1,  v.cs_rd,  1'b0);
        cfg_write(2,  v.cs_wr,  1'b0);
        cfg_write(3,  v.adv_on, 1'b0);
        cfg_write(4,  v.adv_rd, 1'b0);
        cfg_write(5,  v.adv_wr, 1'b0);
        cfg_write(6,  v.oe_on,  1'b0);
        cfg_write(7,  v.oe_off, 1'b0);
        cfg_write(8,  v.we_on,  1'b0);
        cfg_write(9,  v.we_off, 1'b0);
        cfg_write(10, v.rlen,   1'b0);
        cfg_write(11, v.wlen,   1'b0);
        cfg_write(12, v.acc,    1'b0);
        cfg_write(13, v.div,    1'b0);
    endtask

    task automatic run_txn(input vec_t v, input int idx, input bit hold);
        int dv, len, acc, base, done_c, ticks;
        int on_t[4];
        int off_t[4];
        int first[4];
        int lows[4];
        bit wr;
        logic [3:0] stb;
        dv   = int'(v.div);
        wr   = v.wr;
        len  = wr ? int'(v.wlen) : int'(v.rlen);
        acc  = int'(v.acc);
        base = 16'hA000 + idx * 16'h0100;
        on_t[0] = int'(v.cs_on);  off_t[0] = wr ? int'(v.cs_wr)  : int'(v.cs_rd);
        on_t[1] = int'(v.adv_on); off_t[1] = wr ? int'(v.adv_wr) : int'(v.adv_rd);
        on_t[2] = int'(v.oe_on);  off_t[2] = wr ? 0 : int'(v.oe_off);
        on_t[3] = int'(v.we_on);  off_t[3] = wr ? int'(v.we_off) : 0;
        for (int s = 0; s < 4; s++) begin
            first[s] = -1;
            lows[s]  = 0;
        end
        done_c = -1;
        ticks  = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_wdata = DW'(16'h5A00 + idx);
        @(posedge clk);
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            if (!hold || c >= 2) req_valid = 1'b0;
            if (hold) req_write = !wr;
            mem_din = DW'(base + c);
            if (c == 0 && wr) begin
                check(mem_doe == 1'b1, "R4 data drive during write", int'(mem_doe), 1);
                check(mem_dout == DW'(16'h5A00 + idx), "R4 write data on bus",
                      int'(mem_dout), 16'h5A00 + idx);
            end
            if (c == 1 && hold) check(ready == 1'b0, "R2 busy ignores request", int'(ready), 0);
            stb = {we_n, oe_n, adv_n, cs_n};
            for (int s = 0; s < 4; s++) begin
                if (!stb[s]) begin
                    if (first[s] < 0) first[s] = c;
                    lows[s]++;
                end
            end
            if (tick) ticks++;
            if (done) begin
                done_c = c;
                check(stb == 4'hF, "R6 strobes high at done", int'(stb), 15);
                break;
            end
        end
        req_valid = 1'b0;
        check(done_c == len * dv, $sformatf("R6 done latency vec %0d", idx), done_c, len * dv);
        check(ticks == len, $sformatf("R8 tick count vec %0d", idx), ticks, len);
        for (int s = 0; s < 4; s++) begin
            int lim, n;
            lim = (off_t[s] < len) ? off_t[s] : len;
            n   = (lim > on_t[s]) ? (lim - on_t[s]) * dv : 0;
            if (off_t[s] <= on_t[s])
                check(lows[s] == 0, $sformatf("R5 strobe %0d never low vec %0d", s, idx), lows[s], 0);
            else
                check(lows[s] == n, $sformatf("R3 strobe %0d low cycles vec %0d", s, idx), lows[s], n);
            if (n > 0) begin
                if (on_t[s] == 0)
                    check(first[s] == 0, $sformatf("R10 strobe %0d first low vec %0d", s, idx), first[s], 0);
                else
                    check(first[s] == on_t[s] * dv, $sformatf("R3 strobe %0d first low vec %0d", s, idx),
                          first[s], on_t[s] * dv);
            end
        end
        if (!wr && acc < len) exp_rdata = (base + acc * dv + dv - 1) & 16'hFFFF;
        @(negedge clk);
        check(int'(rdata) == exp_rdata, $sformatf("R7 read data vec %0d", idx), int'(rdata), exp_rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        check({we_n, oe_n, adv_n, cs_n} == 4'hF, "R1 strobes high after reset",
              int'({we_n, oe_n, adv_n, cs_n}), 15);
        check(done == 1'b0, "R1 done low after reset", int'(done), 0);
        check(tick == 1'b0, "R1 tick low after reset", int'(tick), 0);
        check(cfg_err == 1'b0, "R1 cfg error low after reset", int'(cfg_err), 0);
        check(rdata == '0, "R1 read data zero after reset", int'(rdata), 0);

        for (int i = 0; i < NV; i++) begin
            load_cfg(VECS[i]);
            run_txn(VECS[i], i, 1'b0);
        end

        load_cfg(VECS[2]);
        run_txn(VECS[2], 7, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(ready == 1'b1, "R2 no cycle from request seen while busy", int'(ready), 1);
            check({we_n, oe_n, adv_n, cs_n} == 4'hF, "R2 strobes stay high",
                  int'({we_n, oe_n, adv_n, cs_n}), 15);
        end

        cfg_write(0, 16, 1'b1);
        cfg_write(1, 32, 1'b1);
        cfg_write(10, 0, 1'b1);
        cfg_write(12, 40, 1'b1);
        cfg_write(13, 0, 1'b1);
        cfg_write(13, 5, 1'b1);
        cfg_write(14, 1, 1'b1);
        cfg_write(15, 3, 1'b1);
        run_txn(VECS[2], 8, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule